// File: doc/BRIEF.md
# Fast Adaptive Channel Length Classifier

This block serves one receiver lane. It picks the equalization code the lane uses by sorting the attached channel into one of two classes, short or long. After a `start` pulse, it waits for a single signed level sample from an external comparator, qualified by `meas_valid`. It compares the magnitude of that sample with a symmetric window whose half-width is `lim_code` × 40 mV. A sample outside the window marks the channel as long. A sample inside the window, or on its edge, marks the channel as short. The block then drives one of two programmed 4-bit EQ codes and keeps that decision until a later measurement replaces it.

When adaptive EQ is off, the block passes through a manual EQ code instead. The `eq_override` input chooses the source of that code: the pin-sampled value or the register value. Integration logic feeds the programmed fields to the block and reads `eq_out` and `long_stat`. Both outputs are registered, so any input change appears one clock edge later.

Top module: `aeq_fast_classifier`

## Requirements
- R1: The fast classifier is active only when `aeq_en` = 1 and `adapt_mode[0]` = 0, which means modes 0 and 2. In modes 1 and 3, `start` and `meas_valid` have no effect, `long_stat` is 0 and `eq_out` is the manual code.
- R2: The window half-width is `lim_code` × 40 mV. The magnitude |`meas_level`| is an integer in mV. If it is greater than the half-width, the channel is classed as long. If it is equal to or less than the half-width, the channel is classed as short. This holds for negative samples too.
- R3: While the held decision is long and the fast classifier is active, `eq_out` equals `long_eq` and `long_stat` is 1.
- R4: While the held decision is short and the fast classifier is active, `eq_out` equals `short_eq` and `long_stat` is 0.
- R5: A decision is taken only on the first `meas_valid` after a `start`. A `meas_valid` that does not follow a `start` is ignored. The decision is held until a later measurement replaces it.
- R6: When `start` and `meas_valid` are high in the same cycle, `start` wins. The measurement is ignored and the block keeps waiting for the next `meas_valid`.
- R7: While `aeq_en` = 0, `long_stat` is 0 and `eq_out` is `reg_eq` when `eq_override` = 1 or `pin_eq` when `eq_override` = 0. The held decision is cleared to short.
- R8: After reset, `eq_out` = 0 and `long_stat` = 0. Until the first decision, the held decision is short.
- R9: Both outputs are registered. A change on any EQ input or on the enables reaches `eq_out` and `long_stat` at the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| aeq_en | input | 1 | Adaptive EQ enable |
| adapt_mode | input | 2 | Adaptation mode; bit 0 = 0 selects the fast classifier |
| eq_override | input | 1 | Manual source select: 1 register value, 0 pin value |
| pin_eq | input | EQ_W | Manual EQ sampled from pins |
| reg_eq | input | EQ_W | Manual EQ from register |
| short_eq | input | EQ_W | EQ code used for a short channel |
| long_eq | input | EQ_W | EQ code used for a long channel |
| lim_code | input | LIM_W | Window code; half-width is code × STEP_MV mV |
| start | input | 1 | Begins a measurement |
| meas_valid | input | 1 | Qualifies `meas_level` |
| meas_level | input | LVL_W | Signed measured level in mV |
| eq_out | output | EQ_W | Applied EQ code |
| long_stat | output | 1 | 1 when the long EQ code is applied |

## Verification
A wrong held decision or a stuck measuring phase shows at the ports within one edge after the next `meas_valid`. Either `eq_out` carries the wrong one of the two programmed codes, or `long_stat` disagrees with the class of the sample. A decision that leaks while the classifier is inactive, or that is not cleared when it is disabled, appears on the first cycle after re-enable as a nonzero `long_stat` before any new measurement. The bench drives samples on both edges of the window and at both signs, so an off-by-one in the magnitude or limit arithmetic flips the status bit in that same cycle.

// File: rtl/aeq_fast_pkg.sv
package aeq_fast_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_MEAS = 1'b1
    } phase_e;

    localparam int unsigned EQ_W_P = 4;

    typedef struct packed {
        phase_e              phase;
        logic                long_dec;
        logic [EQ_W_P-1:0]   eq;
        logic                stat;
    } cls_state_t;

endpackage

// File: rtl/aeq_win_cmp.sv
module aeq_win_cmp #(
    parameter int unsigned LVL_W   = 10,
    parameter int unsigned LIM_W   = 3,
    parameter int unsigned STEP_MV = 40
) (
    input  logic signed [LVL_W-1:0] level,
    input  logic [LIM_W-1:0]        code,
    output logic                    outside
);
    localparam int unsigned CMP_W = LVL_W + LIM_W + 1;

    logic [CMP_W-1:0] mag;
    logic [CMP_W-1:0] half_width;

    always_comb begin
        if (level[LVL_W-1]) begin
            mag = CMP_W'(~level) + CMP_W'(1);
            mag[CMP_W-1:LVL_W] = '0;
        end else begin
            mag = CMP_W'(level);
        end
        half_width = CMP_W'(code) * CMP_W'(STEP_MV);
        outside    = (mag > half_width);
    end
endmodule

// File: rtl/aeq_manual_sel.sv
module aeq_manual_sel #(
    parameter int unsigned EQ_W = 4
) (
    input  logic            use_reg,
    input  logic [EQ_W-1:0] pin_val,
    input  logic [EQ_W-1:0] reg_val,
    output logic [EQ_W-1:0] eq_val
);
    always_comb begin
        eq_val = use_reg ? reg_val : pin_val;
    end
endmodule

// File: rtl/aeq_fast_classifier.sv
module aeq_fast_classifier
    import aeq_fast_pkg::*;
#(
    parameter int unsigned EQ_W    = 4,
    parameter int unsigned LIM_W   = 3,
    parameter int unsigned LVL_W   = 10,
    parameter int unsigned STEP_MV = 40
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    aeq_en,
    input  logic [1:0]              adapt_mode,
    input  logic                    eq_override,
    input  logic [EQ_W-1:0]         pin_eq,
    input  logic [EQ_W-1:0]         reg_eq,
    input  logic [EQ_W-1:0]         short_eq,
    input  logic [EQ_W-1:0]         long_eq,
    input  logic [LIM_W-1:0]        lim_code,
    input  logic                    start,
    input  logic                    meas_valid,
    input  logic signed [LVL_W-1:0] meas_level,
    output logic [EQ_W-1:0]         eq_out,
    output logic                    long_stat
);
    cls_state_t state_d, state_q;

    logic            mode_fast;
    logic            fast_on;
    logic            meas_busy;
    logic            is_long;
    logic [EQ_W-1:0] manual_eq;

    aeq_win_cmp #(
        .LVL_W  (LVL_W),
        .LIM_W  (LIM_W),
        .STEP_MV(STEP_MV)
    ) win_i (
        .level  (meas_level),
        .code   (lim_code),
        .outside(is_long)
    );

    aeq_manual_sel #(
        .EQ_W(EQ_W)
    ) man_i (
        .use_reg(eq_override),
        .pin_val(pin_eq),
        .reg_val(reg_eq),
        .eq_val (manual_eq)
    );

    assign mode_fast = (adapt_mode == 2'b00) || (adapt_mode == 2'b10);
    assign fast_on   = aeq_en && mode_fast;
    assign meas_busy = (state_q.phase == PH_MEAS);

    always_comb begin
        state_d = state_q;
        if (!fast_on) begin
            state_d.phase = PH_IDLE;
            if (!aeq_en) begin
                state_d.long_dec = 1'b0;
            end
        end else if (start) begin
            state_d.phase = PH_MEAS;
        end else if (meas_busy && meas_valid) begin
            state_d.phase    = PH_IDLE;
            state_d.long_dec = is_long;
        end

        if (fast_on) begin
            state_d.eq   = state_d.long_dec ? long_eq : short_eq;
            state_d.stat = state_d.long_dec;
        end else begin
            state_d.eq   = manual_eq;
            state_d.stat = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{phase: PH_IDLE, long_dec: 1'b0, eq: '0, stat: 1'b0};
        end else begin
            state_q <= state_d;
        end
    end

    assign eq_out    = state_q.eq;
    assign long_stat = state_q.stat;
endmodule

// File: rtl/aeq_fast_chk.sv
module aeq_fast_chk #(
    parameter int unsigned EQ_W    = 4,
    parameter int unsigned LIM_W   = 3,
    parameter int unsigned LVL_W   = 10,
    parameter int unsigned STEP_MV = 40
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    aeq_en,
    input logic [1:0]              adapt_mode,
    input logic                    eq_override,
    input logic [EQ_W-1:0]         pin_eq,
    input logic [EQ_W-1:0]         reg_eq,
    input logic [EQ_W-1:0]         short_eq,
    input logic [EQ_W-1:0]         long_eq,
    input logic [LIM_W-1:0]        lim_code,
    input logic                    start,
    input logic                    meas_valid,
    input logic signed [LVL_W-1:0] meas_level,
    input logic [EQ_W-1:0]         eq_out,
    input logic                    long_stat,
    input logic                    busy
);
    logic fast;
    int   mag_i;
    int   lim_i;
    logic ref_long;

    assign fast     = aeq_en && !adapt_mode[0];
    assign mag_i    = (meas_level < 0) ? -int'(meas_level) : int'(meas_level);
    assign lim_i    = int'(lim_code) * int'(STEP_MV);
    assign ref_long = (mag_i > lim_i);

    // R7
    disabled_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !aeq_en |=> !long_stat);

    // R7
    manual_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !aeq_en |=> eq_out == (($past(eq_override)) ? $past(reg_eq) : $past(pin_eq)));

    // R1
    full_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (aeq_en && adapt_mode[0]) |=> !long_stat);

    // R3
    long_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fast |=> (!long_stat || eq_out == $past(long_eq)));

    // R4
    short_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fast |=> (long_stat || eq_out == $past(short_eq)));

    // R2
    classify_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fast && busy && meas_valid && !start) |=> long_stat == $past(ref_long));

    // R5
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fast && $past(fast) && !meas_valid) |=> long_stat == $past(long_stat));

    // R6
    start_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fast && $past(fast) && start) |=> long_stat == $past(long_stat));
endmodule

bind aeq_fast_classifier aeq_fast_chk #(
    .EQ_W   (EQ_W),
    .LIM_W  (LIM_W),
    .LVL_W  (LVL_W),
    .STEP_MV(STEP_MV)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .aeq_en     (aeq_en),
    .adapt_mode (adapt_mode),
    .eq_override(eq_override),
    .pin_eq     (pin_eq),
    .reg_eq     (reg_eq),
    .short_eq   (short_eq),
    .long_eq    (long_eq),
    .lim_code   (lim_code),
    .start      (start),
    .meas_valid (meas_valid),
    .meas_level (meas_level),
    .eq_out     (eq_out),
    .long_stat  (long_stat),
    .busy       (meas_busy)
);

// File: tb/aeq_fast_classifier_tb.sv
module aeq_fast_classifier_tb_top;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              aeq_en = 1'b0;
    logic [1:0]        adapt_mode = 2'b00;
    logic              eq_override = 1'b0;
    logic [3:0]        pin_eq = 4'd0;
    logic [3:0]        reg_eq = 4'd0;
    logic [3:0]        short_eq = 4'd0;
    logic [3:0]        long_eq = 4'd7;
    logic [2:0]        lim_code = 3'd2;
    logic              start = 1'b0;
    logic              meas_valid = 1'b0;
    logic signed [9:0] meas_level = '0;
    logic [3:0]        eq_out;
    logic              long_stat;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    aeq_fast_classifier dut_i (
        .clk(clk), .rst_n(rst_n), .aeq_en(aeq_en), .adapt_mode(adapt_mode),
        .eq_override(eq_override), .pin_eq(pin_eq), .reg_eq(reg_eq),
        .short_eq(short_eq), .long_eq(long_eq), .lim_code(lim_code),
        .start(start), .meas_valid(meas_valid), .meas_level(meas_level),
        .eq_out(eq_out), .long_stat(long_stat)
    );

    task automatic chk(input string req, input logic [3:0] exp_eq, input logic exp_st);
        checks++;
        if (eq_out !== exp_eq || long_stat !== exp_st) begin
            errors++;
            $display("FAIL %s: eq_out=%0d long_stat=%0b expected eq_out=%0d long_stat=%0b",
                     req, eq_out, long_stat, exp_eq, exp_st);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic measure(input int lvl);
        tick(); start = 1'b1;
        tick(); start = 1'b0; meas_valid = 1'b1; meas_level = 10'(lvl);
        tick(); meas_valid = 1'b0;
    endtask

    task automatic t_reset();
        tick();
        chk("R8 reset", 4'd0, 1'b0);
        rst_n = 1'b1;
        tick();
        chk("R8 after release", 4'd0, 1'b0);
    endtask

    task automatic t_disabled();
        aeq_en = 1'b0; pin_eq = 4'd5; reg_eq = 4'd9; eq_override = 1'b0;
        tick();
        chk("R7 pin source", 4'd5, 1'b0);
        eq_override = 1'b1;
        tick();
        chk("R7 reg source", 4'd9, 1'b0);
        measure(400);
        chk("R7 measurement ignored", 4'd9, 1'b0);
    endtask

    task automatic t_window();
        aeq_en = 1'b1; adapt_mode = 2'b00; short_eq = 4'd3; long_eq = 4'd7; lim_code = 3'd2;
        tick();
        chk("R8 short before first decision", 4'd3, 1'b0);
        measure(50);   chk("R4 inside window", 4'd3, 1'b0);
        measure(81);   chk("R3 R2 above limit", 4'd7, 1'b1);
        measure(80);   chk("R2 at limit is short", 4'd3, 1'b0);
        measure(-81);  chk("R2 negative above limit", 4'd7, 1'b1);
        measure(-80);  chk("R2 negative at limit", 4'd3, 1'b0);
        lim_code = 3'd0;
        measure(0);    chk("R2 zero window zero level", 4'd3, 1'b0);
        measure(1);    chk("R2 zero window one mV", 4'd7, 1'b1);
        lim_code = 3'd7;
        measure(280);  chk("R2 widest window edge", 4'd3, 1'b0);
        measure(281);  chk("R2 widest window above", 4'd7, 1'b1);
        measure(10);   chk("R2 widest window small", 4'd3, 1'b0);
        measure(-512); chk("R2 most negative", 4'd7, 1'b1);
    endtask

    task automatic t_hold();
        tick(); meas_valid = 1'b1; meas_level = 10'sd0;
        tick(); meas_valid = 1'b0;
        tick();
        chk("R5 strobe without start ignored", 4'd7, 1'b1);
        long_eq = 4'd12;
        tick();
        chk("R9 long code follows", 4'd12, 1'b1);
    endtask

    task automatic t_priority();
        tick(); start = 1'b1;
        tick(); meas_valid = 1'b1; meas_level = 10'sd0;
        tick(); start = 1'b0; meas_valid = 1'b0;
        chk("R6 start wins same cycle", 4'd12, 1'b1);
        tick(); meas_valid = 1'b1; meas_level = 10'sd5;
        tick(); meas_valid = 1'b0;
        chk("R6 later strobe decides", 4'd3, 1'b0);
    endtask

    task automatic t_modes();
        adapt_mode = 2'b10;
        measure(300);
        chk("R1 mode 2 is fast", 4'd12, 1'b1);
        adapt_mode = 2'b01; eq_override = 1'b0; pin_eq = 4'd6;
        tick();
        chk("R1 full mode manual", 4'd6, 1'b0);
        measure(0);
        adapt_mode = 2'b11;
        tick();
        chk("R1 full mode measurement ignored", 4'd6, 1'b0);
        adapt_mode = 2'b00;
        tick();
        chk("R1 decision kept across full mode", 4'd12, 1'b1);
        aeq_en = 1'b0;
        tick();
        aeq_en = 1'b1;
        tick();
        chk("R7 disable clears decision", 4'd3, 1'b0);
    endtask

    initial begin
        t_reset();
        t_disabled();
        t_window();
        t_hold();
        t_priority();
        t_modes();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule